// File: doc/BRIEF.md
# Receive FIFO Fill Controller with Interrupt Routing

This block sits in the receive data path of a packet radio. A serial bit stream arrives together with a bit clock. While filling is enabled, the block packs the bits into bytes, most significant bit first, and pushes each completed byte into a byte FIFO. Software drains the FIFO through a small byte-wide register bus. The same bus shows the FIFO status flags: full, not-empty and a sticky overrun flag.

Filling can be started in two ways, chosen by a fill-mode bit:
- **Pattern mode:** a pulse from the pattern correlator starts filling and sets a start flag. Software rearms the block by writing 1 to that flag.
- **Software mode:** the same flag acts as a plain run/stop enable.

Two interrupt pins carry internal events, selected by the Rx/Tx mode, the buffered-mode input and select fields in a configuration register. The events are pattern hit, RSSI interrupt, TX stopped, bit clock, byte written, FIFO not-empty and FIFO full.

Top module: `rxf_fill_ctrl`

Register map:
- **Address 0, configuration and status:** bits 7-6 select the Rx IRQ0 source, bits 5-4 select the Rx IRQ1 source, bit 3 selects the Tx IRQ1 source. Bit 2 is full (read-only), bit 1 is not-empty (read-only), bit 0 is overrun.
- **Address 1, fill control:** bit 7 is the fill mode (0 = pattern, 1 = software), bit 6 is the start flag, and bits 5-0 read 0.
- **Address 2, FIFO data:** each read pops one byte.
- **Address 3:** reads 0.

## Requirements
- R1: After reset, the address 0 and address 1 reads return 0x00, the FIFO is empty, and with all event inputs low both IRQ pins are low.
- R2: While filling is active, bit_data is sampled on each rising edge of bit_clk and shifted in MSB first. Every eighth sample forms a byte that enters the FIFO. Reads of address 2 return the bytes in arrival order, one byte removed per read.
- R3: In pattern mode (address 1 bit 7 = 0), a pattern_hit pulse sets address 1 bit 6 and starts filling. The first byte starts with the first bit sampled after the hit; bits sampled before it are not stored. Further hits while bit 6 is set do not realign the byte.
- R4: In pattern mode, writing address 1 with bit 6 = 1 clears the start flag and stops filling. Writing bit 6 = 0 leaves the flag unchanged.
- R5: In software mode (bit 7 = 1), the written bit 6 runs (1) or stops (0) filling. pattern_hit does not change the flag.
- R6: Address 0 bit 2 reads 1 exactly when the FIFO holds its full depth (16 bytes). Bit 1 reads 1 when it holds at least one byte.
- R7: A byte that completes while the FIFO is full is discarded and sets address 0 bit 0. The flag stays set until address 0 is written with bit 0 = 1; writing bit 0 = 0 does not clear it. Writing bit 0 = 1 clears the flag and empties the FIFO.
- R8: Reading address 2 while the FIFO is empty returns 0x00 and removes nothing.
- R9: IRQ0 in Rx mode (tx_mode = 0), selected by address 0 bits 7-6:
  - Unbuffered: code 01 gives rssi_irq; any other code gives pattern_hit.
  - Buffered: 00 gives 0, 01 gives the byte-written strobe, 10 gives FIFO not-empty, 11 gives pattern_hit.
- R10: IRQ1 in Rx mode, selected by address 0 bits 5-4:
  - Unbuffered: bit_clk for every code.
  - Buffered: 00 gives 0, 01 gives FIFO full, 10 and 11 give rssi_irq.
- R11: Tx mode (tx_mode = 1):
  - Unbuffered: IRQ0 is 0 and IRQ1 is bit_clk.
  - Buffered: IRQ0 is FIFO not-empty, and IRQ1 is FIFO full when address 0 bit 3 = 0 or tx_stopped when it is 1.
- R12: The byte-written strobe is high for exactly one clock cycle per completed byte, in the cycle after the byte's final sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | Bit clock, synchronous to clk, rising edge samples data |
| bit_data | input | 1 | Serial receive data |
| pattern_hit | input | 1 | Start-pattern detect pulse |
| rssi_irq | input | 1 | RSSI threshold event |
| tx_stopped | input | 1 | Transmitter stopped event |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| buffered | input | 1 | 1 = buffered (FIFO) operation |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| irq0 | output | 1 | Interrupt pin 0 |
| irq1 | output | 1 | Interrupt pin 1 |

## Verification
The hardest state to reach from the ports is a byte completing against a full FIFO. The stimulus reaches it by running the fill in software mode for sixteen whole bytes and checking the full status, then shifting in a seventeenth byte. Draining all sixteen afterwards shows the extra byte never landed.

Routing through the FIFO-driven sources needs the FIFO held full as well. So the configuration sweep over every mode and select code is repeated while it is in that state.

Pattern alignment is exercised by feeding stray bits before the hit and a second hit in the middle of a byte.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_FILL = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic [1:0] rx_sel0;
        logic [1:0] rx_sel1;
        logic       tx_sel1;
    } irq_cfg_t;

    typedef struct packed {
        logic full;
        logic not_empty;
        logic wr_strobe;
    } fifo_evt_t;

endpackage

// File: rtl/rxf_byte_asm.sv
`timescale 1ns/1ps
module rxf_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_clk,
    input  logic              bit_data,
    input  logic              fill_active,
    output logic              push,
    output logic [BYTE_W-1:0] push_data,
    output logic              wr_strobe
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              bclk;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              strobe;
    } asm_state_t;

    asm_state_t q, d;
    logic rise;

    always_comb begin
        d         = q;
        d.bclk    = bit_clk;
        d.strobe  = 1'b0;
        rise      = bit_clk & ~q.bclk;
        push      = 1'b0;
        push_data = {q.shreg[BYTE_W-2:0], bit_data};
        if (!fill_active) begin
            d.cnt = '0;
        end else if (rise) begin
            d.shreg = push_data;
            if (q.cnt == LAST) begin
                push     = 1'b1;
                d.cnt    = '0;
                d.strobe = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_strobe = q.strobe;

    p_idle_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_active |=> q.cnt == '0);
    p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

endmodule

// File: rtl/rxf_fifo.sv
`timescale 1ns/1ps
module rxf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_req,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         full,
    output logic         not_empty,
    output logic         dropped
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_state_t;

    fifo_state_t q, d;
    logic pop, push_ok;

    always_comb begin
        d       = q;
        pop     = pop_req && (q.cnt != '0);
        push_ok = push && ((q.cnt != CNT_FULL) || pop) && !flush;
        dropped = push && !push_ok && !flush;
        if (flush) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (push_ok) begin
                d.mem[q.wr] = push_data;
                d.wr        = (q.wr == PTR_LAST) ? '0 : q.wr + 1'b1;
            end
            if (pop) begin
                d.rd = (q.rd == PTR_LAST) ? '0 : q.rd + 1'b1;
            end
            d.cnt = q.cnt + CNT_W'(push_ok) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head      = q.mem[q.rd];
    assign full      = (q.cnt == CNT_FULL);
    assign not_empty = (q.cnt != '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_FULL);
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && q.cnt == '0 && !push && !flush) |=> q.cnt == '0);
    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !not_empty);

endmodule

// File: rtl/rxf_irq_route.sv
`timescale 1ns/1ps
module rxf_irq_route
    import rxf_pkg::*;
(
    input  logic      tx_mode,
    input  logic      buffered,
    input  irq_cfg_t  cfg,
    input  fifo_evt_t evt,
    input  logic      pattern_hit,
    input  logic      rssi_irq,
    input  logic      tx_stopped,
    input  logic      bit_clk,
    output logic      irq0,
    output logic      irq1
);
    always_comb begin
        irq0 = 1'b0;
        irq1 = bit_clk;
        if (tx_mode) begin
            if (buffered) begin
                irq0 = evt.not_empty;
                irq1 = cfg.tx_sel1 ? tx_stopped : evt.full;
            end
        end else if (!buffered) begin
            irq0 = (cfg.rx_sel0 == 2'b01) ? rssi_irq : pattern_hit;
        end else begin
            unique case (cfg.rx_sel0)
                2'b00:   irq0 = 1'b0;
                2'b01:   irq0 = evt.wr_strobe;
                2'b10:   irq0 = evt.not_empty;
                default: irq0 = pattern_hit;
            endcase
            unique case (cfg.rx_sel1)
                2'b00:   irq1 = 1'b0;
                2'b01:   irq1 = evt.full;
                default: irq1 = rssi_irq;
            endcase
        end
    end
endmodule

// File: rtl/rxf_fill_ctrl.sv
`timescale 1ns/1ps
module rxf_fill_ctrl
    import rxf_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk,
    input  logic       bit_data,
    input  logic       pattern_hit,
    input  logic       rssi_irq,
    input  logic       tx_stopped,
    input  logic       tx_mode,
    input  logic       buffered,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq0,
    output logic       irq1
);
    localparam int BYTE_W = 8;

    typedef struct packed {
        irq_cfg_t cfg;
        logic     fill_mode;
        logic     start_flag;
        logic     overrun;
    } ctrl_state_t;

    ctrl_state_t q, d;

    logic              wr_cfg, wr_fill, pop_req, flush;
    logic              push, dropped;
    logic [BYTE_W-1:0] push_data, head;
    fifo_evt_t         evt;

    assign wr_cfg  = reg_wr && (reg_addr == ADDR_CFG);
    assign wr_fill = reg_wr && (reg_addr == ADDR_FILL);
    assign pop_req = reg_rd && (reg_addr == ADDR_DATA);
    assign flush   = wr_cfg && reg_wdata[0];

    always_comb begin
        d = q;
        if (dropped) d.overrun = 1'b1;
        if (flush)   d.overrun = 1'b0;
        if (wr_cfg) begin
            d.cfg.rx_sel0 = reg_wdata[7:6];
            d.cfg.rx_sel1 = reg_wdata[5:4];
            d.cfg.tx_sel1 = reg_wdata[3];
        end
        if (!q.fill_mode && pattern_hit) d.start_flag = 1'b1;
        if (wr_fill) begin
            d.fill_mode = reg_wdata[7];
            if (reg_wdata[7])      d.start_flag = reg_wdata[6];
            else if (reg_wdata[6]) d.start_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CFG:  reg_rdata = {q.cfg.rx_sel0, q.cfg.rx_sel1, q.cfg.tx_sel1,
                                    evt.full, evt.not_empty, q.overrun};
            ADDR_FILL: reg_rdata = {q.fill_mode, q.start_flag, 6'b0};
            ADDR_DATA: reg_rdata = evt.not_empty ? head : 8'h00;
            default:   reg_rdata = 8'h00;
        endcase
    end

    rxf_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_clk     (bit_clk),
        .bit_data    (bit_data),
        .fill_active (q.start_flag),
        .push        (push),
        .push_data   (push_data),
        .wr_strobe   (evt.wr_strobe)
    );

    rxf_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop_req   (pop_req),
        .flush     (flush),
        .head      (head),
        .full      (evt.full),
        .not_empty (evt.not_empty),
        .dropped   (dropped)
    );

    rxf_irq_route u_route (
        .tx_mode     (tx_mode),
        .buffered    (buffered),
        .cfg         (q.cfg),
        .evt         (evt),
        .pattern_hit (pattern_hit),
        .rssi_irq    (rssi_irq),
        .tx_stopped  (tx_stopped),
        .bit_clk     (bit_clk),
        .irq0        (irq0),
        .irq1        (irq1)
    );

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.overrun && !flush) |=> q.overrun);
    p_pattern_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.fill_mode && pattern_hit && !wr_fill) |=> q.start_flag);
    p_sw_ignores_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fill_mode && !wr_fill) |=> $stable(q.start_flag));
    p_tx_unbuf_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && !buffered) |-> !irq0);

endmodule

// File: tb/rxf_fill_ctrl_bench.sv
`timescale 1ns/1ps
module rxf_fill_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_clk = 1'b0, bit_data = 1'b0;
    logic       pattern_hit = 1'b0, rssi_irq = 1'b0, tx_stopped = 1'b0;
    logic       tx_mode = 1'b0, buffered = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq0, irq1;

    int n_checks = 0, n_fail = 0;
    int strobe_cnt = 0;
    bit count_strobes = 0;

    always #2 clk = ~clk;

    rxf_fill_ctrl u_rxf_fill_ctrl (.*);

    always @(negedge clk) if (count_strobes && irq0) strobe_cnt++;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_data = b; bit_clk = 1'b1;
        @(negedge clk); bit_clk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_hit();
        @(negedge clk); pattern_hit = 1'b1;
        @(negedge clk); pattern_hit = 1'b0;
    endtask

    function automatic logic [1:0] exp_irq(input logic tx, input logic bf,
            input logic [1:0] s0, input logic [1:0] s1, input logic st,
            input logic pat, input logic rs, input logic ts, input logic dc,
            input logic ne, input logic fu, input logic sb);
        logic i0, i1;
        if (tx) begin
            i0 = bf ? ne : 1'b0;
            i1 = bf ? (st ? ts : fu) : dc;
        end else if (!bf) begin
            i0 = (s0 == 2'b01) ? rs : pat;
            i1 = dc;
        end else begin
            i0 = (s0 == 2'b00) ? 1'b0 : (s0 == 2'b01) ? sb : (s0 == 2'b10) ? ne : pat;
            i1 = (s1 == 2'b00) ? 1'b0 : (s1 == 2'b01) ? fu : rs;
        end
        return {i0, i1};
    endfunction

    task automatic sweep(input logic ne, input logic fu, input bit all_inputs);
        for (int c = 0; c < 128; c++) begin
            logic [1:0] e;
            wr(2'd0, {c[6:5], c[4:3], c[2], 3'b000});
            for (int p = 0; p < (all_inputs ? 16 : 1); p++) begin
                @(negedge clk);
                tx_mode = c[1]; buffered = c[0];
                pattern_hit = p[0]; rssi_irq = p[1]; tx_stopped = p[2]; bit_clk = p[3];
                #1;
                e = exp_irq(c[1], c[0], c[6:5], c[4:3], c[2], p[0], p[1], p[2], p[3], ne, fu, 1'b0);
                if (c[1]) chk("R11 irq pins tx", {6'b0, irq0, irq1}, {6'b0, e});
                else begin
                    chk("R9 irq0 rx", {7'b0, irq0}, {7'b0, e[1]});
                    chk("R10 irq1 rx", {7'b0, irq1}, {7'b0, e[0]});
                end
            end
        end
        @(negedge clk);
        pattern_hit = 0; rssi_irq = 0; tx_stopped = 0; bit_clk = 0; tx_mode = 0; buffered = 0;
        wr(2'd0, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); chk("R1 cfg after reset", v, 8'h00);
        rd(2'd1, v); chk("R1 fill after reset", v, 8'h00);
        chk("R1 irq pins after reset", {6'b0, irq0, irq1}, 8'h00);
        rd(2'd2, v); chk("R8 empty read", v, 8'h00);

        // routing sweep with FIFO empty, software mode stopped
        wr(2'd1, 8'h80);
        sweep(1'b0, 1'b0, 1'b1);

        // R5 software mode: run, pattern ignored, stop
        wr(2'd1, 8'hC0);
        send_byte(8'hA5);
        pulse_hit();
        rd(2'd1, v); chk("R5 flag after hit in sw mode", v, 8'hC0);
        send_byte(8'h3C);
        wr(2'd1, 8'h80);
        rd(2'd1, v); chk("R5 sw stop", v, 8'h80);
        send_byte(8'hFF);
        rd(2'd2, v); chk("R2 first byte msb first", v, 8'hA5);
        rd(2'd2, v); chk("R2 second byte", v, 8'h3C);
        rd(2'd2, v); chk("R5 no byte while stopped / R8 empty", v, 8'h00);
        rd(2'd2, v); chk("R8 second empty read", v, 8'h00);

        // R3 pattern mode alignment
        wr(2'd1, 8'h00);
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        rd(2'd0, v); chk("R3 stray bits not stored", v & 8'h06, 8'h00);
        pulse_hit();
        rd(2'd1, v); chk("R3 hit sets flag", v, 8'h40);
        send_bit(1); send_bit(0); send_bit(0);
        pulse_hit();
        send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        send_byte(8'h5A);
        rd(2'd2, v); chk("R3 first aligned byte", v, 8'h96);
        rd(2'd2, v); chk("R3 second byte", v, 8'h5A);

        // R4 rearm
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R4 write 0 keeps flag", v, 8'h40);
        wr(2'd1, 8'h40);
        rd(2'd1, v); chk("R4 write 1 clears flag", v, 8'h00);
        send_byte(8'h77);
        rd(2'd0, v); chk("R4 no fill after clear", v, 8'h00);

        // R6 / R7 full and overrun
        wr(2'd1, 8'hC0);
        for (int i = 0; i < 16; i++) begin
            send_byte(8'(i * 17 + 3));
            if (i == 0) begin
                rd(2'd0, v); chk("R6 not empty one byte", v, 8'h02);
            end
        end
        rd(2'd0, v); chk("R6 full status", v, 8'h06);
        sweep(1'b1, 1'b1, 1'b0);
        send_byte(8'hEE);
        rd(2'd0, v); chk("R7 overrun set", v, 8'h07);
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R7 write 0 keeps overrun", v, 8'h07);
        wr(2'd1, 8'h80);
        for (int i = 0; i < 16; i++) begin
            rd(2'd2, v); chk("R7 stored order, extra dropped", v, 8'(i * 17 + 3));
        end
        rd(2'd0, v); chk("R7 sticky after drain", v, 8'h01);
        wr(2'd1, 8'hC0);
        send_byte(8'h12); send_byte(8'h34);
        rd(2'd0, v); chk("R6 two bytes status", v, 8'h03);
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R7 flush and clear", v, 8'h00);
        rd(2'd2, v); chk("R7 flushed read", v, 8'h00);

        // R12 byte-written strobe on irq0
        wr(2'd1, 8'h80);
        buffered = 1'b1;
        wr(2'd0, 8'h40);
        wr(2'd1, 8'hC0);
        count_strobes = 1;
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        repeat (3) @(negedge clk);
        count_strobes = 0;
        chk("R12 strobe cycles", 8'(strobe_cnt), 8'd3);
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h80);
        @(negedge clk); #1;
        chk("R9 buffered not-empty source", {7'b0, irq0}, 8'h01);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule